// File: doc/BRIEF.md
# Multi-Record Triggered Acquisition Sequencer

This block is the control core of a digitizer's capture engine. Software arms it with an initiate strobe. It then steps each record through a fixed chain of phases. It waits for a start trigger once per acquisition. It samples a minimum number of pre-trigger samples, then waits for an arming trigger and a reference trigger while sampling goes on. After the reference trigger it takes a fixed number of post-trigger samples. It then hands the record to memory and waits for the write to be acknowledged. Before each further record it waits for an advance trigger.

Each trigger input has an enable. With the enable low, the trigger is treated as unconfigured and its wait phase passes in a single cycle. Leaving the pre-trigger phase needs three things in the same cycle: enough pre-trigger samples, a ready flag from the time-to-digital converter, and an expired holdoff timer. The holdoff timer is reloaded each time post-trigger sampling begins, and it is not checked on the first record.

The controller raises pulses for the start trigger, a record write, end of record and end of acquisition. It holds the finished acquisition until software clears it.

Top module: `acq_sequencer`

## Requirements
- R1: After reset the state code is 0 (Idle) and every pulse output and sampleEn are low. The state codes are: 0 Idle, 1 wait-start, 2 min-pretrigger, 3 wait-arm, 4 wait-reference, 5 post-trigger, 6 record-complete, 7 wait-advance, 8 done.
- R2: An initiate sampled in Idle gives state 1 in the next cycle. The pretrigger count, post-trigger count, record count and holdoff values are captured at that edge, and later changes to those inputs have no effect on the acquisition. Initiate is ignored in every other state.
- R3: When the enable of the start, arm, reference or advance trigger is low, its wait state lasts exactly one cycle.
- R4: When a trigger's enable is high, its wait state holds until the trigger input is sampled high at a clock edge, and the state advances at that same edge.
- R5: startPulse is high for exactly one cycle, the first cycle of state 2, and only once per acquisition.
- R6: With holdoff met and tdcReady high, state 2 lasts max(P,1) cycles, where P is the pretrigger count. While tdcReady is low, state 2 is held.
- R7: The holdoff counter is loaded with H at the edge that enters state 5 and then counts down by one each cycle. It must be zero to leave state 2, except on the first record. For each record after the first, state 2 lasts max(P, H−Q−1) cycles, where Q = max(post-trigger count, 1), advance is untriggered and memory acknowledges at once.
- R8: sampleEn is high exactly in states 2, 3, 4 and 5.
- R9: State 5 lasts max(post-trigger count, 1) cycles.
- R10: recordWrite pulses for one cycle, the first cycle of state 6. State 6 holds until memStored is sampled high.
- R11: The record count N is taken as max(N,1). endRecordPulse is high in the cycle after leaving state 6. The next state is 7 if records remain, otherwise 8. Leaving state 7 enters state 2.
- R12: endAcqPulse is high in the first cycle of state 8, together with endRecordPulse. State 8 holds until clearFetch, which returns the controller to state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initiate | input | 1 | Software start of an acquisition |
| clearFetch | input | 1 | Software release of a finished acquisition |
| startTrig | input | 1 | Start trigger pulse |
| startTrigEn | input | 1 | Start trigger configured (0 = none) |
| armTrig | input | 1 | Arm-reference trigger pulse |
| armTrigEn | input | 1 | Arm-reference trigger configured |
| refTrig | input | 1 | Reference trigger pulse |
| refTrigEn | input | 1 | Reference trigger configured |
| advTrig | input | 1 | Advance trigger pulse |
| advTrigEn | input | 1 | Advance trigger configured |
| cfgPreCount | input | CNT_W | Minimum pretrigger samples |
| cfgPostCount | input | CNT_W | Post-trigger samples |
| cfgRecords | input | REC_W | Number of records |
| cfgHoldoff | input | HOLD_W | Trigger-to-trigger holdoff cycles |
| tdcReady | input | 1 | Time-to-digital converter ready |
| memStored | input | 1 | Record stored acknowledge |
| sampleEn | output | 1 | Sampling active |
| recordWrite | output | 1 | Record write request pulse |
| stateCode | output | 4 | Current state code |
| startPulse | output | 1 | Start trigger generated |
| endRecordPulse | output | 1 | End of record event |
| endAcqPulse | output | 1 | End of acquisition event |

## Verification
On the last record, the exit from record-complete raises the end-of-record and end-of-acquisition events in the same cycle, the first cycle of done. Every run of the sweep ends this way, and the bench requires both pulses to be high in that cycle. The sweep also varies the holdoff against the pretrigger count, so that the holdoff expiry and the pretrigger count completion fall on the same cycle in some runs and one of them governs the exit in others. The bench compares the number of busy cycles and the number of sampling cycles against closed-form totals.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE     = 4'd0,
    ST_WSTART   = 4'd1,
    ST_MINPRE   = 4'd2,
    ST_WARM     = 4'd3,
    ST_WREF     = 4'd4,
    ST_POST     = 4'd5,
    ST_RECDONE  = 4'd6,
    ST_WADV     = 4'd7,
    ST_DONE     = 4'd8
  } acqState_e;

  // control -> datapath
  typedef struct packed {
    logic loadCfg;
    logic preRun;
    logic postRun;
    logic holdLoad;
    logic recAdvance;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic preDone;
    logic postDone;
    logic holdOk;
    logic lastRec;
  } dpStatus_t;

endpackage

// File: rtl/acq_seq_span_counter.sv
module acq_seq_span_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         run,
  input  logic [W-1:0] len,
  output logic         done
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) cnt <= '0;
    else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  // the current cycle's sample is the last one when cnt+1 reaches len
  logic [W:0] nextCount;
  assign nextCount = {1'b0, cnt} + {{W{1'b0}}, 1'b1};
  assign done = (nextCount >= {1'b0, len});
endmodule

// File: rtl/acq_seq_datapath.sv
module acq_seq_datapath
  import acq_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REC_W  = 8,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [CNT_W-1:0]  cfgPreCount,
  input  logic [CNT_W-1:0]  cfgPostCount,
  input  logic [REC_W-1:0]  cfgRecords,
  input  logic [HOLD_W-1:0] cfgHoldoff,
  output dpStatus_t         status
);
  localparam int NSPAN = 2;

  logic [CNT_W-1:0]  spanLen [NSPAN];
  logic [CNT_W-1:0]  spanCfg [NSPAN];
  logic              spanRun [NSPAN];
  logic              spanDone[NSPAN];
  logic [HOLD_W-1:0] holdLen;
  logic [HOLD_W-1:0] holdCnt;
  logic              firstRec;
  logic [REC_W-1:0]  recLeft;

  assign spanCfg[0] = cfgPreCount;
  assign spanCfg[1] = cfgPostCount;
  assign spanRun[0] = strobe.preRun;
  assign spanRun[1] = strobe.postRun;

  // one working length register and one counter per sampling span
  for (genvar g = 0; g < NSPAN; g++) begin : gSpan
    always_ff @(posedge clk) begin
      if (!rstN) spanLen[g] <= '0;
      else if (strobe.loadCfg) spanLen[g] <= spanCfg[g];
    end

    acq_seq_span_counter #(.W(CNT_W)) uSpan (
      .clk  (clk),
      .rstN (rstN),
      .run  (spanRun[g]),
      .len  (spanLen[g]),
      .done (spanDone[g])
    );
  end

  // holdoff timer: reloaded at post-trigger entry, free-runs down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdLen  <= '0;
      holdCnt  <= '0;
      firstRec <= 1'b0;
    end else begin
      if (strobe.loadCfg) begin
        holdLen  <= cfgHoldoff;
        holdCnt  <= '0;
        firstRec <= 1'b1;
      end else if (strobe.holdLoad) begin
        holdCnt  <= holdLen;
        firstRec <= 1'b0;
      end else if (holdCnt != '0) begin
        holdCnt <= holdCnt - 1'b1;
      end
    end
  end

  // remaining records, zero treated as one
  always_ff @(posedge clk) begin
    if (!rstN) recLeft <= '0;
    else if (strobe.loadCfg)
      recLeft <= (cfgRecords == '0) ? {{(REC_W-1){1'b0}}, 1'b1} : cfgRecords;
    else if (strobe.recAdvance && recLeft != '0)
      recLeft <= recLeft - 1'b1;
  end

  assign status.preDone  = spanDone[0];
  assign status.postDone = spanDone[1];
  assign status.holdOk   = firstRec || (holdCnt == '0);
  assign status.lastRec  = (recLeft <= {{(REC_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       initiate,
  input  logic       clearFetch,
  input  logic       startTrig,
  input  logic       startTrigEn,
  input  logic       armTrig,
  input  logic       armTrigEn,
  input  logic       refTrig,
  input  logic       refTrigEn,
  input  logic       advTrig,
  input  logic       advTrigEn,
  input  logic       tdcReady,
  input  logic       memStored,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output acqState_e  state,
  output logic       sampleEn,
  output logic       recordWrite,
  output logic       startPulse,
  output logic       endRecordPulse,
  output logic       endAcqPulse
);
  acqState_e stateNext;
  logic startGo, armGo, refGo, advGo, preExit, postExit, recExit;

  // an unconfigured trigger counts as already present
  assign startGo  = !startTrigEn || startTrig;
  assign armGo    = !armTrigEn   || armTrig;
  assign refGo    = !refTrigEn   || refTrig;
  assign advGo    = !advTrigEn   || advTrig;
  assign preExit  = status.preDone && tdcReady && status.holdOk;
  assign postExit = status.postDone;
  assign recExit  = memStored;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (initiate)   stateNext = ST_WSTART;
      ST_WSTART:  if (startGo)    stateNext = ST_MINPRE;
      ST_MINPRE:  if (preExit)    stateNext = ST_WARM;
      ST_WARM:    if (armGo)      stateNext = ST_WREF;
      ST_WREF:    if (refGo)      stateNext = ST_POST;
      ST_POST:    if (postExit)   stateNext = ST_RECDONE;
      ST_RECDONE: if (recExit)    stateNext = status.lastRec ? ST_DONE : ST_WADV;
      ST_WADV:    if (advGo)      stateNext = ST_MINPRE;
      ST_DONE:    if (clearFetch) stateNext = ST_IDLE;
      default:                    stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.loadCfg    = (state == ST_IDLE) && initiate;
    strobe.preRun     = (state == ST_MINPRE);
    strobe.postRun    = (state == ST_POST);
    strobe.holdLoad   = (state == ST_WREF) && refGo;
    strobe.recAdvance = (state == ST_RECDONE) && recExit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state          <= ST_IDLE;
      startPulse     <= 1'b0;
      recordWrite    <= 1'b0;
      endRecordPulse <= 1'b0;
      endAcqPulse    <= 1'b0;
    end else begin
      state          <= stateNext;
      startPulse     <= (state == ST_WSTART) && startGo;
      recordWrite    <= (state == ST_POST) && postExit;
      endRecordPulse <= strobe.recAdvance;
      endAcqPulse    <= strobe.recAdvance && status.lastRec;
    end
  end

  always_comb begin
    unique case (state)
      ST_MINPRE, ST_WARM, ST_WREF, ST_POST: sampleEn = 1'b1;
      default:                              sampleEn = 1'b0;
    endcase
  end
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_seq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int REC_W  = 8,
  parameter int HOLD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initiate,
  input  logic              clearFetch,
  input  logic              startTrig,
  input  logic              startTrigEn,
  input  logic              armTrig,
  input  logic              armTrigEn,
  input  logic              refTrig,
  input  logic              refTrigEn,
  input  logic              advTrig,
  input  logic              advTrigEn,
  input  logic [CNT_W-1:0]  cfgPreCount,
  input  logic [CNT_W-1:0]  cfgPostCount,
  input  logic [REC_W-1:0]  cfgRecords,
  input  logic [HOLD_W-1:0] cfgHoldoff,
  input  logic              tdcReady,
  input  logic              memStored,
  output logic              sampleEn,
  output logic              recordWrite,
  output logic [3:0]        stateCode,
  output logic              startPulse,
  output logic              endRecordPulse,
  output logic              endAcqPulse
);
  ctlStrobe_t strobe;
  dpStatus_t  status;
  acqState_e  state;

  acq_seq_ctrl uCtrl (
    .clk            (clk),
    .rstN           (rstN),
    .initiate       (initiate),
    .clearFetch     (clearFetch),
    .startTrig      (startTrig),
    .startTrigEn    (startTrigEn),
    .armTrig        (armTrig),
    .armTrigEn      (armTrigEn),
    .refTrig        (refTrig),
    .refTrigEn      (refTrigEn),
    .advTrig        (advTrig),
    .advTrigEn      (advTrigEn),
    .tdcReady       (tdcReady),
    .memStored      (memStored),
    .status         (status),
    .strobe         (strobe),
    .state          (state),
    .sampleEn       (sampleEn),
    .recordWrite    (recordWrite),
    .startPulse     (startPulse),
    .endRecordPulse (endRecordPulse),
    .endAcqPulse    (endAcqPulse)
  );

  acq_seq_datapath #(.CNT_W(CNT_W), .REC_W(REC_W), .HOLD_W(HOLD_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgPreCount  (cfgPreCount),
    .cfgPostCount (cfgPostCount),
    .cfgRecords   (cfgRecords),
    .cfgHoldoff   (cfgHoldoff),
    .status       (status)
  );

  assign stateCode = state;
endmodule

// File: rtl/acq_seq_checker.sv
module acq_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       initiate,
  input logic       clearFetch,
  input logic       startTrig,
  input logic       startTrigEn,
  input logic       tdcReady,
  input logic       memStored,
  input logic [3:0] stateCode,
  input logic       sampleEn,
  input logic       startPulse,
  input logic       endRecordPulse,
  input logic       endAcqPulse
);
  assert_init_entry_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd0 && initiate) |=> (stateCode == 4'd1));

  assert_start_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd1 && startTrigEn && !startTrig) |=> (stateCode == 4'd1));

  assert_start_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> (stateCode == 4'd2 && $past(stateCode) == 4'd1));

  assert_tdc_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd2 && !tdcReady) |=> (stateCode == 4'd2));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd0 || stateCode == 4'd8) |-> !sampleEn);

  assert_mem_wait_R10: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd6 && !memStored) |=> (stateCode == 4'd6));

  assert_done_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stateCode == 4'd8 && !clearFetch) |=> (stateCode == 4'd8));

  assert_acq_end_R12: assert property (@(posedge clk) disable iff (!rstN)
    endAcqPulse |-> (endRecordPulse && stateCode == 4'd8));
endmodule

bind acq_sequencer acq_seq_checker uChecker (.*);

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
  localparam int CNT_W = 8, REC_W = 4, HOLD_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic initiate = 0, clearFetch = 0;
  logic startTrig = 0, startTrigEn = 0, armTrig = 0, armTrigEn = 0;
  logic refTrig = 0, refTrigEn = 0, advTrig = 0, advTrigEn = 0;
  logic [CNT_W-1:0] cfgPreCount = '0, cfgPostCount = '0;
  logic [REC_W-1:0] cfgRecords = '0;
  logic [HOLD_W-1:0] cfgHoldoff = '0;
  logic tdcReady = 1, memStored = 1;
  logic sampleEn, recordWrite, startPulse, endRecordPulse, endAcqPulse;
  logic [3:0] stateCode;

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  acq_sequencer #(.CNT_W(CNT_W), .REC_W(REC_W), .HOLD_W(HOLD_W)) uut (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic int maxi(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // near-exhaustive sweep, triggers unconfigured, tdc ready, memory immediate
  task automatic runCase(int pre, int post, int rec, int hold);
    int p = maxi(pre, 1), q = maxi(post, 1), n = maxi(rec, 1);
    int later = maxi(p, hold - q - 1);
    int expBusy = 1 + (p + 3 + q) + (n - 1) * (later + 4 + q);
    int expSamp = p + 2 + q + (n - 1) * (later + 2 + q);
    int busy = 0, samp = 0, starts = 0, recs = 0, writes = 0, acqs = 0, guard = 0;
    bit both = 0;
    cfgPreCount = CNT_W'(pre); cfgPostCount = CNT_W'(post);
    cfgRecords = REC_W'(rec); cfgHoldoff = HOLD_W'(hold);
    initiate = 1;
    tick();
    initiate = 0;
    // R2: configuration changes after initiate must not matter
    cfgPreCount = CNT_W'(pre + 5); cfgPostCount = CNT_W'(post + 4);
    cfgRecords = REC_W'(rec + 2); cfgHoldoff = HOLD_W'(hold + 7);
    while (stateCode != 4'd8 && guard < 1000) begin
      busy++; guard++;
      if (sampleEn) samp++;
      if (startPulse) starts++;
      if (recordWrite) writes++;
      if (endRecordPulse) recs++;
      if (endAcqPulse) acqs++;
      tick();
    end
    if (endRecordPulse) recs++;
    if (endAcqPulse) acqs++;
    both = endRecordPulse && endAcqPulse;
    chk($sformatf("R7 R6 R9 R2 busy cycles pre=%0d post=%0d rec=%0d hold=%0d", pre, post, rec, hold), busy, expBusy);
    chk("R8 sampling cycles", samp, expSamp);
    chk("R5 start pulses", starts, 1);
    chk("R10 record writes", writes, n);
    chk("R11 end of record pulses", recs, n);
    chk("R12 end of acquisition pulses", acqs, 1);
    chk("R12 end pulses coincide", int'(both), 1);
    clearFetch = 1;
    tick();
    clearFetch = 0;
    chk("R12 clear returns to idle", stateCode, 0);
  endtask

  task automatic expectState(string req, int code);
    chk(req, stateCode, code);
  endtask

  initial begin
    repeat (3) tick();
    rstN = 1;
    tick();
    // R1 reset state
    chk("R1 state after reset", stateCode, 0);
    chk("R1 sampleEn after reset", sampleEn, 0);
    chk("R1 pulses after reset", {startPulse, recordWrite, endRecordPulse, endAcqPulse}, 0);

    // directed run with every trigger configured
    cfgPreCount = 2; cfgPostCount = 2; cfgRecords = 2; cfgHoldoff = 0;
    startTrigEn = 1; armTrigEn = 1; refTrigEn = 1; advTrigEn = 1;
    tdcReady = 0; memStored = 0;
    initiate = 1; tick(); initiate = 0;
    expectState("R2 initiate enters wait-start", 1);
    for (int i = 0; i < 3; i++) begin
      tick();
      expectState("R4 wait-start holds", 1);
      chk("R5 no start pulse while waiting", startPulse, 0);
    end
    startTrig = 1; tick(); startTrig = 0;
    expectState("R4 start trigger advances", 2);
    chk("R5 start pulse on entry", startPulse, 1);
    for (int i = 0; i < 4; i++) begin
      tick();
      expectState("R6 tdc not ready holds pretrigger", 2);
    end
    chk("R5 start pulse single cycle", startPulse, 0);
    tdcReady = 1; tick();
    expectState("R6 leaves once tdc ready", 3);
    for (int i = 0; i < 2; i++) begin
      tick(); expectState("R4 arm wait holds", 3);
    end
    armTrig = 1; tick(); armTrig = 0;
    expectState("R4 arm trigger advances", 4);
    chk("R8 sampling in reference wait", sampleEn, 1);
    tick(); expectState("R4 reference wait holds", 4);
    refTrig = 1; tick(); refTrig = 0;
    expectState("R9 post-trigger entered", 5);
    tick(); expectState("R9 post lasts two cycles", 5);
    tick(); expectState("R10 record complete", 6);
    chk("R10 record write pulse", recordWrite, 1);
    chk("R8 no sampling in record complete", sampleEn, 0);
    for (int i = 0; i < 3; i++) begin
      tick(); expectState("R10 waits for memory", 6);
      chk("R10 write pulse single", recordWrite, 0);
    end
    memStored = 1; tick(); memStored = 0;
    expectState("R11 records remain go to advance wait", 7);
    chk("R11 end of record pulse", endRecordPulse, 1);
    chk("R11 no end of acquisition yet", endAcqPulse, 0);
    for (int i = 0; i < 2; i++) begin
      tick(); expectState("R4 advance wait holds", 7);
    end
    advTrig = 1; tick(); advTrig = 0;
    expectState("R11 advance returns to pretrigger", 2);
    chk("R5 no second start pulse", startPulse, 0);
    tick(); expectState("R6 pretrigger second cycle", 2);
    tick(); expectState("R6 pretrigger done", 3);
    armTrig = 1; tick(); armTrig = 0;
    refTrig = 1; tick(); refTrig = 0;
    expectState("R4 second reference", 5);
    tick(); tick();
    expectState("R10 second record complete", 6);
    memStored = 1; tick();
    expectState("R12 done after last record", 8);
    chk("R12 end of acquisition pulse", endAcqPulse, 1);
    chk("R12 end of record with it", endRecordPulse, 1);
    initiate = 1; tick(); initiate = 0;
    expectState("R2 initiate ignored in done", 8);
    chk("R12 end of acquisition single", endAcqPulse, 0);
    clearFetch = 1; tick(); clearFetch = 0;
    expectState("R12 clear to idle", 0);

    // R3 sweep with unconfigured triggers
    startTrigEn = 0; armTrigEn = 0; refTrigEn = 0; advTrigEn = 0;
    tdcReady = 1; memStored = 1;
    for (int pre = 0; pre < 4; pre++)
      for (int post = 0; post < 4; post++)
        for (int rec = 0; rec < 4; rec++)
          foreach (holdSet[h]) runCase(pre, post, rec, holdSet[h]);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  int holdSet[3] = '{0, 4, 9};

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule